// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block receives asynchronous serial frames. A single-cycle enable pulse at sixteen times the bit rate paces it. It finds the falling edge that opens a start bit and confirms that bit halfway through. It then samples every following bit in the middle of its slot, least significant bit first. It checks the optional parity bit and the first stop bit. Each completed frame is either moved into a holding data register or held back, and a small status register records the outcome.

The status register holds four flags: data-full, overrun, framing error and parity error. The flags and the data transfer follow fixed rules when errors occur one at a time or together. A frame that completes while any flag is still set becomes an overrun: the earlier data is kept, and every applicable error flag is raised as well. A line held low keeps producing framing errors with zero data. Software reads the data register and clears flags over a simple register port.

Top module: `serial_rx_core`

## Requirements
- R1: After reset, all four status flags and the data register read zero.
- R2: Bits are sampled every sixteen enable pulses, starting eight pulses after the start edge is seen. The first received bit lands in data bit 0.
- R3: A start bit that is high again at its mid-point abandons the frame and changes no flag and no data.
- R4: A frame with no error and no pending flag loads the data register and sets data-full.
- R5: A frame whose first stop bit samples low, with no flag pending, loads the data register and sets the framing flag. Data-full stays 0.
- R6: With parity enabled, even mode expects an even count of ones over the data and parity bits, and odd mode expects an odd count. A mismatch with no flag pending loads the data register and sets the parity flag.
- R7: A frame completing while any flag is set leaves the data register unchanged and sets overrun. It also sets the framing and parity flags if that frame has those errors. Data-full keeps its value.
- R8: A continuous low line gives a framing error with data 0x00. Once the framing flag is cleared, a further framing error follows without any other action.
- R9: The register port has address 0 for data and address 1 for status, with bit0 data-full, bit1 overrun, bit2 framing and bit3 parity. Writing status clears each flag whose write bit is 0 and leaves flags whose bit is 1. Reading address 0 clears data-full.
- R10: In seven-bit mode, seven data bits are received and data bit 7 reads 0.
- R11: With two stop bits selected, the second stop slot is not checked. A low level early in that slot raises no error and starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_i | input | 1 | Serial line, idle high |
| tick16_i | input | 1 | Enable pulse at 16x the bit rate |
| cfg_seven_i | input | 1 | 1 selects seven data bits, 0 selects eight |
| cfg_par_en_i | input | 1 | Parity bit present and checked |
| cfg_par_odd_i | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_two_stop_i | input | 1 | Two stop bits, with only the first checked |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 1 | 0 selects data, 1 selects status |
| bus_wdata_i | input | 4 | Status write value; a 0 bit clears that flag |
| bus_rdata_o | output | 8 | Read value of the addressed register |

## Verification
Random frames mix both data widths, all parity modes and one or two stop bits. Parity and stop errors are injected, and the reads and clears in between are chosen at random, so clean loads, single errors, combined errors and overruns all arise against a bench model of the flag rules. Directed cases add three more checks. A half-bit glitch shows that the start recheck differs from a real start. A held-low line shows that a break repeats as framing errors with zero data. A short low in the second stop slot shows that this slot goes unchecked. A run of identical patterns could not show that LSB-first ordering and the parity sense are right, so the random data covers both.

// File: rtl/rx_pkg.sv
package rx_pkg;
  // flag word: bit0 full, bit1 overrun, bit2 framing, bit3 parity
  typedef struct packed {
    logic per;
    logic fer;
    logic ovr;
    logic full;
  } rx_flags_t;

  // expected parity bit for the received data
  function automatic logic par_expect(input logic [7:0] d, input logic odd);
    return (^d) ^ odd;
  endfunction

  // outcome of one completed frame applied to the flags
  function automatic rx_flags_t frame_merge(input rx_flags_t f, input logic busy,
                                            input logic fe, input logic pe);
    rx_flags_t n;
    n = f;
    if (busy) begin
      n.ovr = 1'b1;
      n.fer = f.fer | fe;
      n.per = f.per | pe;
    end else if (fe || pe) begin
      n.fer = fe;
      n.per = pe;
    end else begin
      n.full = 1'b1;
    end
    return n;
  endfunction
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] pipe;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pipe <= '1;
    else        pipe <= {pipe[STAGES-2:0], d_i};
  end
  assign q_o = pipe[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer #(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              rx_i,
  input  logic              seven_i,
  input  logic              par_en_i,
  input  logic              par_odd_i,
  input  logic              two_stop_i,
  output logic              done_o,
  output logic              abort_o,
  output logic [DATA_W-1:0] data_o,
  output logic              fe_o,
  output logic              pe_o
);
  localparam int CW   = $clog2(OSR);
  localparam int IW   = $clog2(DATA_W);
  localparam logic [CW-1:0] HALF_M1 = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] FULL_M1 = CW'(OSR - 1);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_STOP2} st_t;
  st_t st;
  logic [CW-1:0]     cnt;
  logic [IW-1:0]     idx;
  logic [DATA_W-1:0] shreg;
  logic              parbit;
  logic [IW-1:0]     last_idx;
  logic              slot_end;

  assign last_idx = seven_i ? IW'(DATA_W-2) : IW'(DATA_W-1);
  assign slot_end = tick_i && (cnt == FULL_M1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; idx <= '0; shreg <= '0; parbit <= 1'b0;
    end else if (tick_i) begin
      case (st)
        S_IDLE: if (!rx_i) begin
          st <= S_START; cnt <= '0; shreg <= '0;
        end
        S_START: if (cnt == HALF_M1) begin
          st <= rx_i ? S_IDLE : S_DATA; cnt <= '0; idx <= '0;
        end else cnt <= cnt + 1'b1;
        S_DATA: if (cnt == FULL_M1) begin
          shreg[idx] <= rx_i; cnt <= '0; idx <= idx + 1'b1;
          if (idx == last_idx) st <= par_en_i ? S_PAR : S_STOP;
        end else cnt <= cnt + 1'b1;
        S_PAR: if (cnt == FULL_M1) begin
          parbit <= rx_i; cnt <= '0; st <= S_STOP;
        end else cnt <= cnt + 1'b1;
        S_STOP: if (cnt == FULL_M1) begin
          cnt <= '0; st <= two_stop_i ? S_STOP2 : S_IDLE;
        end else cnt <= cnt + 1'b1;
        S_STOP2: if (cnt == FULL_M1) begin
          cnt <= '0; st <= S_IDLE;
        end else cnt <= cnt + 1'b1;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign done_o  = slot_end && (st == S_STOP);
  assign abort_o = tick_i && (st == S_START) && (cnt == HALF_M1) && rx_i;
  assign data_o  = shreg;
  assign fe_o    = !rx_i;
  assign pe_o    = par_en_i && (parbit != rx_pkg::par_expect(shreg, par_odd_i));
endmodule

// File: rtl/rx_regs.sv
module rx_regs #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              done_i,
  input  logic              fe_i,
  input  logic              pe_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              rd_data_i,
  input  logic              wr_stat_i,
  input  logic [3:0]        wmask_i,
  output logic [3:0]        flags_o,
  output logic [DATA_W-1:0] rdr_o,
  output logic              busy_o
);
  import rx_pkg::*;
  rx_flags_t flags_q, cleared, flags_n;
  logic [DATA_W-1:0] rdr_q;

  assign busy_o = |flags_q;

  always_comb begin
    cleared = flags_q;
    if (wr_stat_i) cleared = flags_q & rx_flags_t'(wmask_i);
    if (rd_data_i) cleared.full = 1'b0;
    flags_n = done_i ? frame_merge(cleared, busy_o, fe_i, pe_i) : cleared;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      rdr_q   <= '0;
    end else begin
      flags_q <= flags_n;
      if (done_i && !busy_o) rdr_q <= data_i;
    end
  end

  assign flags_o = flags_q;
  assign rdr_o   = rdr_q;
endmodule

// File: rtl/serial_rx_core.sv
module serial_rx_core #(
  parameter int OSR    = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_i,
  input  logic              tick16_i,
  input  logic              cfg_seven_i,
  input  logic              cfg_par_en_i,
  input  logic              cfg_par_odd_i,
  input  logic              cfg_two_stop_i,
  input  logic              bus_rd_i,
  input  logic              bus_wr_i,
  input  logic              bus_addr_i,
  input  logic [3:0]        bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o
);
  logic              rx_s;
  logic              frame_done, frame_abort, frm_fe, frm_pe, ovr_evt;
  logic [DATA_W-1:0] frm_data, rdr_q;
  logic [3:0]        flags_q;
  logic              rd_data_strobe, wr_stat_strobe;

  assign rd_data_strobe = bus_rd_i && !bus_addr_i;
  assign wr_stat_strobe = bus_wr_i && bus_addr_i;

  rx_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(rx_i), .q_o(rx_s)
  );

  rx_framer #(.OSR(OSR), .DATA_W(DATA_W)) u_framer (
    .clk(clk), .rst_n(rst_n), .tick_i(tick16_i), .rx_i(rx_s),
    .seven_i(cfg_seven_i), .par_en_i(cfg_par_en_i), .par_odd_i(cfg_par_odd_i),
    .two_stop_i(cfg_two_stop_i), .done_o(frame_done), .abort_o(frame_abort),
    .data_o(frm_data), .fe_o(frm_fe), .pe_o(frm_pe)
  );

  rx_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .done_i(frame_done), .fe_i(frm_fe), .pe_i(frm_pe),
    .data_i(frm_data), .rd_data_i(rd_data_strobe), .wr_stat_i(wr_stat_strobe),
    .wmask_i(bus_wdata_i), .flags_o(flags_q), .rdr_o(rdr_q), .busy_o(ovr_evt)
  );

  assign bus_rdata_o = bus_addr_i ? {{(DATA_W-4){1'b0}}, flags_q} : rdr_q;
endmodule

// File: rtl/rx_chk.sv
module rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              abort,
  input logic              busy,
  input logic              fe,
  input logic              pe,
  input logic [DATA_W-1:0] shift,
  input logic [3:0]        flags,
  input logic [DATA_W-1:0] rdr,
  input logic              rd_data,
  input logic              wr_stat
);
  // R7
  ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && busy |=> flags[1] && $stable(rdr));
  // R4
  clean_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !busy && !fe && !pe |=> flags[0] && rdr == $past(shift));
  // R5
  err_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done && !busy && (fe || pe) |=> !flags[0] && flags[2] == $past(fe)
      && flags[3] == $past(pe) && rdr == $past(shift));
  // R3
  glitch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort && !rd_data && !wr_stat |=> $stable(flags) && $stable(rdr));
  // R9
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data && !done |=> !flags[0]);
  // R9
  no_spont_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> !$rose(flags[1]));
  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> !rst_n || (flags == 4'b0 || $past(done)));
endmodule

bind serial_rx_core rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done(frame_done), .abort(frame_abort),
  .busy(ovr_evt), .fe(frm_fe), .pe(frm_pe), .shift(frm_data),
  .flags(flags_q), .rdr(rdr_q), .rd_data(rd_data_strobe), .wr_stat(wr_stat_strobe)
);

// File: tb/sim_serial_rx_core.sv
module sim_serial_rx_core;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx = 1'b1;
  logic seven = 1'b0, par_en = 1'b0, par_odd = 1'b0, two = 1'b0;
  logic rd = 1'b0, wr = 1'b0, addr = 1'b0;
  logic [3:0] wdata = '0;
  logic [7:0] rdata;
  logic [1:0] tdiv = '0;
  logic tick;
  int n_chk = 0, n_bad = 0;
  logic [3:0] e_fl = '0;   // bit0 full, bit1 ovr, bit2 fer, bit3 per
  logic [7:0] e_rdr = '0;

  always #4 clk = ~clk;
  always @(negedge clk) tdiv <= tdiv + 2'd1;
  assign tick = (tdiv == 2'd3);

  serial_rx_core u0 (
    .clk(clk), .rst_n(rst_n), .rx_i(rx), .tick16_i(tick),
    .cfg_seven_i(seven), .cfg_par_en_i(par_en), .cfg_par_odd_i(par_odd),
    .cfg_two_stop_i(two), .bus_rd_i(rd), .bus_wr_i(wr), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wait_ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      while (!tick) @(posedge clk);
    end
    @(negedge clk);
  endtask

  task automatic bus_read(input logic a, output logic [7:0] v);
    @(negedge clk); addr = a; rd = 1'b1; #1 v = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic bus_write(input logic [3:0] v);
    @(negedge clk); addr = 1'b1; wdata = v; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  function automatic logic par_bit(input logic [7:0] d, input logic odd);
    int ones = 0;
    for (int b = 0; b < 8; b++) if (d[b]) ones++;
    return (ones % 2 == 1) ? ~odd : odd;
  endfunction

  // bench rule for one completed frame
  task automatic model_frame(input logic [7:0] d, input logic fe, input logic pe);
    if (e_fl != 4'b0) begin
      e_fl[1] = 1'b1;
      if (fe) e_fl[2] = 1'b1;
      if (pe) e_fl[3] = 1'b1;
    end else begin
      e_rdr = d;
      if (fe || pe) begin e_fl[2] = fe; e_fl[3] = pe; end
      else e_fl[0] = 1'b1;
    end
  endtask

  task automatic send(input logic [7:0] d, input logic bad_par, input logic bad_stop,
                      input logic low2);
    int nb;
    logic [7:0] dm;
    nb = seven ? 7 : 8;
    dm = seven ? {1'b0, d[6:0]} : d;
    wait_ticks(1);
    rx = 1'b0; wait_ticks(16);
    for (int b = 0; b < nb; b++) begin rx = dm[b]; wait_ticks(16); end
    if (par_en) begin rx = par_bit(dm, par_odd) ^ bad_par; wait_ticks(16); end
    if (bad_stop) begin rx = 1'b0; wait_ticks(12); rx = 1'b1; wait_ticks(4); end
    else begin rx = 1'b1; wait_ticks(16); end
    if (two) begin
      if (low2) begin rx = 1'b0; wait_ticks(6); rx = 1'b1; wait_ticks(10); end
      else wait_ticks(16);
    end
    rx = 1'b1; wait_ticks(16);
    model_frame(dm, bad_stop, par_en && bad_par);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    bus_read(1'b1, v); check("R1 status", v, 8'h00);
    bus_read(1'b0, v); check("R1 data", v, 8'h00);

    // R2 R4 directed LSB-first clean frame
    send(8'hA1, 1'b0, 1'b0, 1'b0);
    bus_read(1'b1, v); check("R4 status", v, {4'b0, e_fl});
    bus_read(1'b0, v); check("R2 data order", v, 8'hA1); e_fl[0] = 1'b0;
    bus_read(1'b1, v); check("R9 read clears full", v, 8'h00);

    // R3 glitch while full is set
    send(8'h3C, 1'b0, 1'b0, 1'b0);
    wait_ticks(1); rx = 1'b0; wait_ticks(4); rx = 1'b1; wait_ticks(40);
    bus_read(1'b1, v); check("R3 glitch status", v, {4'b0, e_fl});
    bus_read(1'b0, v); check("R3 glitch data", v, e_rdr); e_fl[0] = 1'b0;

    // R7 overrun together with framing error
    send(8'h55, 1'b0, 1'b0, 1'b0);
    send(8'h0F, 1'b0, 1'b1, 1'b0);
    bus_read(1'b1, v); check("R7 ovr+fer status", v, 8'h07);
    bus_read(1'b0, v); check("R7 data kept", v, 8'h55);
    bus_write(4'b0000); e_fl = '0;
    bus_read(1'b1, v); check("R9 write-0 clears", v, 8'h00);

    // R6 R11 odd parity, two stops, early low in second stop
    par_en = 1'b1; par_odd = 1'b1; two = 1'b1;
    send(8'h96, 1'b0, 1'b0, 1'b1);
    bus_read(1'b1, v); check("R11 no error", v, 8'h01);
    bus_read(1'b0, v); check("R11 data", v, 8'h96); e_fl[0] = 1'b0;
    send(8'h96, 1'b1, 1'b0, 1'b0);
    bus_read(1'b1, v); check("R6 parity flag", v, 8'h08);
    bus_write(4'b1011); e_fl[2] = 1'b0;
    bus_read(1'b1, v); check("R9 write-1 keeps", v, 8'h08);
    bus_write(4'b0000); e_fl = '0;

    // R10 seven-bit frame
    seven = 1'b1; par_en = 1'b0; two = 1'b0;
    send(8'hFF, 1'b0, 1'b0, 1'b0);
    bus_read(1'b0, v); check("R10 bit7 zero", v, 8'h7F); e_fl[0] = 1'b0;
    seven = 1'b0;

    // R8 line break
    wait_ticks(1); rx = 1'b0; wait_ticks(160);
    bus_read(1'b1, v); check("R8 break fer", v, 8'h04);
    bus_read(1'b0, v); check("R8 break data", v, 8'h00);
    bus_write(4'b0000);
    wait_ticks(160);
    bus_read(1'b1, v); check("R8 repeat fer", v, 8'h04);
    rx = 1'b1; wait_ticks(200);
    bus_write(4'b0000); e_fl = '0; e_rdr = 8'h00;
    bus_read(1'b1, v); check("R8 recovered", v, 8'h00);
    bus_read(1'b0, v); check("R8 data stays zero", v, 8'h00);

    // random frames: R2 R4 R5 R6 R7 R9 R10 R11
    for (int i = 0; i < 48; i++) begin
      logic [7:0] d;
      logic bp, bs, l2;
      int act;
      seven = $urandom % 2; par_en = $urandom % 2; par_odd = $urandom % 2;
      two = $urandom % 2;
      d = 8'($urandom);
      bp = ($urandom % 4) == 0;
      bs = ($urandom % 5) == 0;
      l2 = two && (($urandom % 2) == 0);
      send(d, bp, bs, l2);
      bus_read(1'b1, v); check("R7 random status", v, {4'b0, e_fl});
      act = $urandom % 3;
      if (act == 0) begin
        bus_read(1'b0, v); check("R4 random data", v, e_rdr); e_fl[0] = 1'b0;
      end else if (act == 1) begin
        bus_write(4'b0000); e_fl = '0;
      end
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule